// File: doc/BRIEF.md
# Vector Carryless Multiply-Long Unit

This execution unit performs widening multiplication over GF(2), in which partial products are combined by XOR and no carry ever moves between bit positions. It serves a machine with 128-bit vector registers. The unit takes a 32-bit instruction word and two 128-bit source values. From the instruction it reads the element shape, and it reads which 64-bit half of each source to use. It then produces a 128-bit result.

Two element shapes exist. The first is eight independent byte lanes, where each lane gives a 16-bit product. The second is a single 64-by-64 product that gives a full 128-bit value. An instruction word outside the supported encoding is rejected with an illegal-instruction pulse, and the result is not marked valid.

The multiplier is iterative. It retires `STEP_BITS` multiplier bits per clock cycle. A `start_i` pulse taken while the unit is idle captures the instruction and both operands. `done_o` then pulses once the accumulated product is ready.

Top module: `clmul_long_unit`

## Requirements
- R1: The instruction is accepted only if every fixed bit matches the pattern 0x0E20E000 under the mask 0xBF20FC00. The variable fields are bits 4:0, 9:5, 20:16, 23:22 and 30. On any mismatch, `illegal_o` pulses for one cycle in the cycle after the start edge, and `done_o` stays low.
- R2: The size field is bits 23:22. Values 1 and 2 are reserved: they raise `illegal_o` exactly as in R1 and never assert `done_o`.
- R3: Size 0 is the byte-lane form. Result bits 16k+15:16k hold the carryless product of byte k of the selected half of source A and byte k of the selected half of source B, for k = 0..7. Bit 15 of every lane is zero.
- R4: Size 3 is the wide form. `result_o` holds the complete 128-bit carryless product of the two selected 64-bit halves, with product bit j at result bit j.
- R5: Instruction bit 30 picks the half of each source. When it is 0, source bits 63:0 are used. When it is 1, source bits 127:64 are used.
- R6: For an accepted legal start, `done_o` is high for exactly one cycle. That cycle comes N cycles after the start edge. N is 64/STEP_BITS for the wide form and max(1, 8/STEP_BITS) for the byte form. `busy_o` is high from the start edge until `done_o` rises.
- R7: The operands and the instruction are captured at the start edge. Changes to the source inputs afterwards do not affect the result. A `start_i` that arrives while `busy_o` is high is ignored, and this holds even for an illegal word.
- R8: After synchronous reset, `done_o`, `illegal_o` and `busy_o` are low and `result_o` is zero.
- R9: `result_o` keeps its value until the next accepted legal start. It is unchanged by idle cycles and by rejected instructions.
- R10: The register-number fields in bits 4:0, 9:5 and 20:16 have no effect on legality or on the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Request to begin an operation; taken only when idle |
| insn_i | input | 32 | Instruction word |
| src_a_i | input | 128 | First source vector (multiplier) |
| src_b_i | input | 128 | Second source vector (multiplicand) |
| result_o | output | 128 | Product vector, held until the next accepted start |
| done_o | output | 1 | One-cycle pulse marking a valid result |
| illegal_o | output | 1 | One-cycle pulse for a rejected instruction word |
| busy_o | output | 1 | Operation in progress |

## Verification
The bench builds the unit with STEP_BITS = 8. At that setting a byte-lane operation finishes in one cycle and a wide operation takes eight. This makes it cheap to cover all 65,536 pairs of 8-bit operands: each operation packs eight pairs into its lanes, and the bench alternates between the lower and upper source halves with unrelated data in the unused half. Wide products come from a pseudo-random sequence plus the all-ones and single-bit corner cases. The bench also flips every fixed opcode bit one at a time, tries both reserved sizes, and checks that operand changes and a second start during the eight-cycle wide window leave the result unchanged.

// File: rtl/clmul_pkg.sv
package clmul_pkg;

    localparam int unsigned INSN_W   = 32;
    localparam int unsigned VEC_W    = 128;
    localparam int unsigned HALF_W   = VEC_W / 2;
    localparam int unsigned LANE_W   = 8;
    localparam int unsigned LANE_CNT = HALF_W / LANE_W;

    // Fixed-bit pattern and mask of the multiply-long encoding class.
    localparam logic [INSN_W-1:0] OPC_PATTERN = 32'h0E20_E000;
    localparam logic [INSN_W-1:0] OPC_MASK    = 32'hBF20_FC00;

    localparam int unsigned SIZE_LO  = 22;
    localparam int unsigned HALF_BIT = 30;

    typedef enum logic [1:0] {
        SZ_BYTE = 2'd0,
        SZ_RSV1 = 2'd1,
        SZ_RSV2 = 2'd2,
        SZ_WIDE = 2'd3
    } elem_size_e;

    typedef struct packed {
        logic       legal;
        logic       wide;
        logic       upper;
        elem_size_e size;
    } op_decode_t;

    typedef struct packed {
        logic [HALF_W-1:0] mul;
        logic [HALF_W-1:0] mcand;
    } operand_pair_t;

    function automatic logic [HALF_W-1:0] pick_half(
        input logic [VEC_W-1:0] v,
        input logic             upper
    );
        return upper ? v[VEC_W-1:HALF_W] : v[HALF_W-1:0];
    endfunction

    // Number of multiplier bits a shape needs.
    function automatic int unsigned shape_bits(input logic wide);
        return wide ? HALF_W : LANE_W;
    endfunction

endpackage

// File: rtl/clmul_decode.sv
module clmul_decode
    import clmul_pkg::*;
(
    input  logic [INSN_W-1:0] insn_i,
    output op_decode_t        dec_o
);
    logic       class_hit;
    elem_size_e size;

    always_comb begin
        class_hit = ((insn_i & OPC_MASK) == OPC_PATTERN);
        size      = elem_size_e'(insn_i[SIZE_LO+1:SIZE_LO]);
        dec_o.size  = size;
        dec_o.upper = insn_i[HALF_BIT];
        dec_o.wide  = (size == SZ_WIDE);
        unique case (size)
            SZ_BYTE, SZ_WIDE: dec_o.legal = class_hit;
            default:          dec_o.legal = 1'b0;
        endcase
    end

    // R2: reserved sizes never decode as legal
    always_comb begin
        a_r2_reserved_size: assert (!(dec_o.legal &&
            (insn_i[SIZE_LO+1:SIZE_LO] == 2'd1 || insn_i[SIZE_LO+1:SIZE_LO] == 2'd2)));
    end

endmodule

// File: rtl/clmul_src_select.sv
module clmul_src_select
    import clmul_pkg::*;
(
    input  logic [VEC_W-1:0] src_a_i,
    input  logic [VEC_W-1:0] src_b_i,
    input  logic             upper_i,
    output operand_pair_t    ops_o
);
    always_comb begin
        ops_o.mul   = pick_half(src_a_i, upper_i);
        ops_o.mcand = pick_half(src_b_i, upper_i);
    end
endmodule

// File: rtl/clmul_engine.sv
module clmul_engine
    import clmul_pkg::*;
#(
    parameter int unsigned STEP_BITS = 4
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              go_i,
    input  logic              wide_i,
    input  operand_pair_t     ops_i,
    output logic [VEC_W-1:0]  acc_o,
    output logic              busy_o,
    output logic              done_o
);
    localparam int unsigned BASE_W = $clog2(HALF_W) + 2;
    localparam logic [BASE_W-1:0] STEP = BASE_W'(STEP_BITS);
    localparam logic [BASE_W-1:0] LIM_BYTE = BASE_W'(LANE_W);
    localparam logic [BASE_W-1:0] LIM_WIDE = BASE_W'(HALF_W);

    logic [HALF_W-1:0] a_q, b_q;
    logic [VEC_W-1:0]  acc_q, acc_d, wide_nxt, byte_nxt;
    logic [BASE_W-1:0] base_q;
    logic              busy_q, done_q, wide_q, last_step;

    assign last_step = (base_q + STEP) >= (wide_q ? LIM_WIDE : LIM_BYTE);

    // Wide form: STEP_BITS rows of the 64x64 shift-and-xor array per cycle.
    always_comb begin
        logic [BASE_W-1:0] idx;
        wide_nxt = acc_q;
        for (int s = 0; s < STEP_BITS; s++) begin
            idx = base_q + BASE_W'(s);
            if (idx < LIM_WIDE && a_q[idx[$clog2(HALF_W)-1:0]])
                wide_nxt = wide_nxt ^ ({{HALF_W{1'b0}}, b_q} << idx[$clog2(HALF_W)-1:0]);
        end
    end

    // Byte form: independent 8x8 arrays, one per lane.
    for (genvar k = 0; k < LANE_CNT; k++) begin : g_lane
        logic [2*LANE_W-1:0] lane_acc;
        always_comb begin
            logic [BASE_W-1:0] idx;
            lane_acc = acc_q[2*LANE_W*k +: 2*LANE_W];
            for (int s = 0; s < STEP_BITS; s++) begin
                idx = base_q + BASE_W'(s);
                if (idx < LIM_BYTE && a_q[LANE_W*k + int'(idx[$clog2(LANE_W)-1:0])])
                    lane_acc = lane_acc ^
                        ({{LANE_W{1'b0}}, b_q[LANE_W*k +: LANE_W]} << idx[$clog2(LANE_W)-1:0]);
            end
        end
        assign byte_nxt[2*LANE_W*k +: 2*LANE_W] = lane_acc;
    end

    assign acc_d = wide_q ? wide_nxt : byte_nxt;

    always_ff @(posedge clk) begin
        if (rst) begin
            a_q    <= '0;
            b_q    <= '0;
            acc_q  <= '0;
            base_q <= '0;
            busy_q <= 1'b0;
            done_q <= 1'b0;
            wide_q <= 1'b0;
        end else begin
            done_q <= 1'b0;
            if (go_i && !busy_q) begin
                a_q    <= ops_i.mul;
                b_q    <= ops_i.mcand;
                wide_q <= wide_i;
                acc_q  <= '0;
                base_q <= '0;
                busy_q <= 1'b1;
            end else if (busy_q) begin
                acc_q  <= acc_d;
                base_q <= base_q + STEP;
                if (last_step) begin
                    busy_q <= 1'b0;
                    done_q <= 1'b1;
                end
            end
        end
    end

    assign acc_o  = acc_q;
    assign busy_o = busy_q;
    assign done_o = done_q;

    // R6: completion only follows a busy cycle
    a_r6_done_after_busy: assert property (@(posedge clk) disable iff (rst)
        done_q |-> ($past(busy_q) && !busy_q));

    // R3: byte-lane products never use their top bit
    a_r3_lane_msb_zero: assert property (@(posedge clk) disable iff (rst)
        (done_q && !wide_q) |-> (acc_q[15] == 1'b0 && acc_q[31] == 1'b0 &&
                                 acc_q[47] == 1'b0 && acc_q[63] == 1'b0 &&
                                 acc_q[79] == 1'b0 && acc_q[95] == 1'b0 &&
                                 acc_q[111] == 1'b0 && acc_q[127] == 1'b0));

    // R9: accumulator is frozen while idle and not restarted
    a_r9_result_hold: assert property (@(posedge clk) disable iff (rst)
        (!busy_q && !go_i) |=> $stable(acc_q));

endmodule

// File: rtl/clmul_long_unit.sv
module clmul_long_unit
    import clmul_pkg::*;
#(
    parameter int unsigned STEP_BITS = 4
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start_i,
    input  logic [31:0]  insn_i,
    input  logic [127:0] src_a_i,
    input  logic [127:0] src_b_i,
    output logic [127:0] result_o,
    output logic         done_o,
    output logic         illegal_o,
    output logic         busy_o
);
    op_decode_t    dec;
    operand_pair_t ops;
    logic          busy, accept, go, illegal_q;

    clmul_decode u_dec (
        .insn_i (insn_i),
        .dec_o  (dec)
    );

    clmul_src_select u_sel (
        .src_a_i (src_a_i),
        .src_b_i (src_b_i),
        .upper_i (dec.upper),
        .ops_o   (ops)
    );

    assign accept = start_i && !busy;
    assign go     = accept && dec.legal;

    clmul_engine #(.STEP_BITS(STEP_BITS)) u_eng (
        .clk    (clk),
        .rst    (rst),
        .go_i   (go),
        .wide_i (dec.wide),
        .ops_i  (ops),
        .acc_o  (result_o),
        .busy_o (busy),
        .done_o (done_o)
    );

    always_ff @(posedge clk) begin
        if (rst) illegal_q <= 1'b0;
        else     illegal_q <= accept && !dec.legal;
    end

    assign illegal_o = illegal_q;
    assign busy_o    = busy;

    // R1: reject and complete are mutually exclusive
    a_r1_no_done_on_illegal: assert property (@(posedge clk) disable iff (rst)
        !(done_o && illegal_o));

    // R7: a start during an operation is never reported as rejected
    a_r7_busy_start_ignored: assert property (@(posedge clk) disable iff (rst)
        (busy && start_i) |=> !illegal_o);

    // R6: a legal start makes the unit busy on the next cycle
    a_r6_busy_after_go: assert property (@(posedge clk) disable iff (rst)
        go |=> busy_o);

endmodule

// File: tb/sim_clmul_long_unit.sv
`timescale 1ns/1ps
module sim_clmul_long_unit;
    localparam int STEP = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         start_i = 1'b0;
    logic [31:0]  insn_i = '0;
    logic [127:0] src_a_i = '0, src_b_i = '0;
    logic [127:0] result_o;
    logic         done_o, illegal_o, busy_o;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    clmul_long_unit #(.STEP_BITS(STEP)) u0 (
        .clk(clk), .rst(rst), .start_i(start_i), .insn_i(insn_i),
        .src_a_i(src_a_i), .src_b_i(src_b_i), .result_o(result_o),
        .done_o(done_o), .illegal_o(illegal_o), .busy_o(busy_o)
    );

    function automatic logic [31:0] mk(input logic [1:0] sz, input logic up,
                                       input logic [4:0] rd, input logic [4:0] rn,
                                       input logic [4:0] rm);
        return 32'h0E20E000 | (32'(up) << 30) | (32'(sz) << 22) |
               (32'(rm) << 16) | (32'(rn) << 5) | 32'(rd);
    endfunction

    function automatic logic [127:0] ref_wide(input logic [63:0] a, input logic [63:0] b);
        logic [127:0] r = '0;
        for (int i = 0; i < 64; i++)
            if (a[i]) r = r ^ (128'(b) << i);
        return r;
    endfunction

    function automatic logic [127:0] ref_bytes(input logic [63:0] a, input logic [63:0] b);
        logic [127:0] r = '0;
        for (int k = 0; k < 8; k++) begin
            logic [15:0] p = '0;
            for (int i = 0; i < 8; i++)
                if (a[8*k+i]) p = p ^ (16'(b[8*k +: 8]) << i);
            r[16*k +: 16] = p;
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input logic [127:0] act,
                         input logic [127:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // Issue one start; returns cycles until done/illegal and which occurred.
    task automatic run_op(input logic [31:0] w, input logic [127:0] a,
                          input logic [127:0] b, output int lat,
                          output bit got_done, output bit got_ill);
        @(negedge clk);
        insn_i = w; src_a_i = a; src_b_i = b; start_i = 1'b1;
        @(posedge clk);
        @(negedge clk);
        start_i = 1'b0;
        src_a_i = ~a; src_b_i = {b[63:0], b[127:64]};
        lat = 0;
        while (!done_o && !illegal_o && lat < 100) begin
            @(negedge clk);
            lat++;
        end
        got_done = done_o;
        got_ill  = illegal_o;
    endtask

    logic [63:0] lfsr = 64'h1234_5678_9ABC_DEF1;
    function automatic logic [63:0] nxt(input logic [63:0] x);
        return {x[62:0], x[63] ^ x[62] ^ x[60] ^ x[59]};
    endfunction

    initial begin
        #(200000 * 4);
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 128'd0, 128'd1);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        int lat;
        bit d, il;
        logic [127:0] held, exp, a, b;
        logic [63:0] ha, hb;

        repeat (3) @(negedge clk);
        // R8: reset state
        check(done_o == 0 && illegal_o == 0 && busy_o == 0 && result_o == 0,
              "R8", {busy_o, illegal_o, done_o, result_o[124:0]}, 128'd0);
        rst = 1'b0;

        // R3/R5 stated vectors
        run_op(mk(0, 0, 1, 2, 3), {2{64'h00000DECAFC0FFEE}}, {2{64'h00000DECAFC0FFEE}}, lat, d, il);
        check(d && result_o == {64'h0000000000515450, 64'h4455500055555454}, "R3",
              result_o, {64'h0000000000515450, 64'h4455500055555454});
        run_op(mk(0, 1, 0, 0, 0), {2{64'hAAAAAAAA55555555}}, {2{64'hAAAAAAAA55555555}}, lat, d, il);
        check(d && result_o == {64'h4444444444444444, 64'h1111111111111111}, "R5",
              result_o, {64'h4444444444444444, 64'h1111111111111111});

        // R3/R5/R6/R10: exhaustive byte pairs, eight per operation
        for (int op = 0; op < 8192; op++) begin
            logic up;
            up = op[0];
            for (int k = 0; k < 8; k++) begin
                int p;
                p = op * 8 + k;
                ha[8*k +: 8] = 8'(p >> 8);
                hb[8*k +: 8] = 8'(p);
            end
            lfsr = nxt(lfsr);
            a = up ? {ha, lfsr} : {lfsr, ha};
            b = up ? {hb, ~lfsr} : {~lfsr, hb};
            run_op(mk(0, up, 5'(op), 5'(op >> 5), 5'(op >> 10)), a, b, lat, d, il);
            exp = ref_bytes(ha, hb);
            check(d && !il && result_o == exp, up ? "R3 R5 upper" : "R3 R10 lower", result_o, exp);
            if (op % 512 == 0)
                check(lat == 1, "R6 byte latency", 128'(lat), 128'd1);
        end

        // R4/R5/R6: wide products
        for (int n = 0; n < 300; n++) begin
            logic up;
            up = n[1];
            lfsr = nxt(lfsr); ha = lfsr;
            lfsr = nxt(lfsr); hb = lfsr;
            if (n == 0) begin ha = '1; hb = '1; end
            if (n == 1) begin ha = 64'h8000_0000_0000_0000; hb = 64'h8000_0000_0000_0000; end
            if (n == 2) begin ha = 64'h1; hb = 64'hFFFF_0000_1234_5678; end
            if (n == 3) begin ha = 64'h0; hb = '1; end
            a = up ? {ha, ~hb} : {hb, ha};
            b = up ? {hb, ha} : {~ha, hb};
            run_op(mk(3, up, 5'(n), 5'(n + 3), 5'(n + 7)), a, b, lat, d, il);
            exp = ref_wide(ha, hb);
            check(d && !il && result_o == exp, up ? "R4 R5 upper" : "R4 lower", result_o, exp);
            check(lat == 8, "R6 wide latency", 128'(lat), 128'd8);
        end

        // R6: done is a single-cycle pulse
        @(negedge clk);
        check(done_o == 0, "R6 pulse width", 128'(done_o), 128'd0);

        // R1/R9: every fixed bit flipped alone
        held = result_o;
        for (int bt = 0; bt < 32; bt++) begin
            if (32'hBF20FC00 & (32'h1 << bt)) begin
                run_op(mk(0, 0, 0, 0, 0) ^ (32'h1 << bt), '1, '1, lat, d, il);
                check(il && !d && lat == 0, "R1 fixed bit", 128'(bt), 128'(bt));
                @(negedge clk);
                check(!illegal_o && !done_o, "R1 pulse", 128'(illegal_o), 128'd0);
                check(result_o == held, "R9 hold on reject", result_o, held);
            end
        end

        // R2: reserved sizes, both halves
        for (int s = 1; s <= 2; s++)
            for (int u = 0; u <= 1; u++) begin
                run_op(mk(2'(s), 1'(u), 4, 5, 6), '1, '1, lat, d, il);
                check(il && !d && lat == 0, "R2 reserved size", 128'(s), 128'(s));
                check(result_o == held, "R9 hold on reserved", result_o, held);
            end

        // R7: changes and a second start during a wide operation
        ha = 64'hDEAD_BEEF_0F0F_1234; hb = 64'hC001_D00D_8421_7777;
        @(negedge clk);
        insn_i = mk(3, 0, 1, 1, 1); src_a_i = {64'h0, ha}; src_b_i = {64'h0, hb}; start_i = 1;
        @(posedge clk);
        @(negedge clk);
        insn_i = 32'hFFFF_FFFF; src_a_i = '1; src_b_i = '1;
        @(negedge clk);
        start_i = 0;
        lat = 1;
        while (!done_o && !illegal_o && lat < 100) begin @(negedge clk); lat++; end
        exp = ref_wide(ha, hb);
        check(done_o && !illegal_o && result_o == exp, "R7 capture", result_o, exp);
        check(lat == 8, "R7 latency unchanged", 128'(lat), 128'd8);

        // R9: idle cycles keep the result
        repeat (5) @(negedge clk);
        check(result_o == exp, "R9 idle hold", result_o, exp);

        // R8: reset in the middle of an operation
        run_op(mk(0, 0, 0, 0, 0), '1, '1, lat, d, il);
        @(negedge clk);
        insn_i = mk(3, 0, 0, 0, 0); start_i = 1;
        @(negedge clk);
        start_i = 0; rst = 1;
        @(negedge clk);
        rst = 0;
        check(!busy_o && !done_o && !illegal_o && result_o == 0, "R8 mid reset",
              result_o, 128'd0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule